// File: doc/BRIEF.md
# Paddle and Ball Motion Controller

This block holds the moving parts of a two-object bat-and-ball game drawn on a 640 by 480 raster. It watches the scan position coming from a separate sync generator and decodes a single-clock frame strobe once per field. On that strobe, and only then, it steps a paddle up or down under two push buttons, moves a square ball diagonally, and turns the ball around when it meets the upper or lower screen edge, a fixed wall near the left edge, or the paddle near the right edge.

The boundaries of both objects leave the block as plain coordinates, so that an object renderer can compare them against the scan position. If the ball slips past the paddle and leaves the right side of the screen, the block raises a one-clock miss pulse and puts the ball back at its start point with its start direction.

Top module: `pong_motion`

## Requirements
- R1: `frame_tick` is high in exactly those cycles where `pix_tick` is 1, `scan_y` equals 481 and `scan_x` equals 0.
- R2: In a cycle without `frame_tick`, the paddle and ball coordinate outputs do not change, whatever the buttons do.
- R3: After reset the paddle top is 204 and its bottom 275. The ball spans columns 320 to 327 and rows 240 to 247. Its start direction is right and down, and `miss` is 0.
- R4: On a frame strobe with `btn_down` high, the paddle moves down by 4 rows if its bottom row is less than 476. `btn_down` wins when both buttons are high.
- R5: On a frame strobe with only `btn_up` high, the paddle moves up by 4 rows if its top row is greater than 4.
- R6: On a frame strobe the ball's vertical direction becomes downward when its top row is 0. It becomes upward when its bottom row is 479 or more.
- R7: On a frame strobe the ball's horizontal direction becomes rightward when its left column is 35 or less, which is the wall's right column.
- R8: On a frame strobe the ball's horizontal direction becomes leftward only when its right column lies within 600 to 603 and its rows overlap the paddle's rows.
- R9: On a frame strobe where the ball's right column exceeds 639, `miss` is 1 for exactly the following cycle. The ball returns to its start position and start direction.
- R10: On every other frame strobe the ball moves 2 columns and 2 rows in its current (updated) directions. Ball right is left+7, ball bottom is top+7, and paddle bottom is top+71.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_tick | input | 1 | Pixel-rate enable from the sync generator |
| scan_x | input | 10 | Current scan column |
| scan_y | input | 10 | Current scan row |
| btn_down | input | 1 | Move paddle down |
| btn_up | input | 1 | Move paddle up |
| frame_tick | output | 1 | Once-per-frame update strobe |
| pad_top | output | 10 | Paddle top row |
| pad_bot | output | 10 | Paddle bottom row |
| ball_xl | output | 10 | Ball left column |
| ball_xr | output | 10 | Ball right column |
| ball_yt | output | 10 | Ball top row |
| ball_yb | output | 10 | Ball bottom row |
| miss | output | 1 | One-cycle pulse when the ball passes the paddle |

## Verification
The bench drives the paddle into both travel limits. A wrong comparison there would leave the paddle one step short of the edge or push it past row 479. It runs a long rally in which the paddle tracks the ball, so that returns off the paddle, the wall, the top and the bottom all occur. A design that tests the paddle's column range or row overlap wrongly would either let the ball through or reflect it in empty space. A separate run parks the paddle at the top so that the ball escapes. This exposes a miss pulse that lasts too long, or a reload that keeps the old direction. Strobe decoding is probed at near-miss scan positions, where a loose decode would move objects several times per frame.

// File: rtl/pong_motion.sv
module pong_motion #(
  parameter int CW       = 10,
  parameter int SCR_W    = 640,
  parameter int SCR_H    = 480,
  parameter int TICK_ROW = 481,
  parameter int PAD_XL   = 600,
  parameter int PAD_XR   = 603,
  parameter int PAD_H    = 72,
  parameter int PAD_STEP = 4,
  parameter int WALL_XR  = 35,
  parameter int BALL_SZ  = 8,
  parameter int BALL_SPD = 2,
  parameter int BALL_X0  = 320,
  parameter int BALL_Y0  = 240
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pix_tick,
  input  logic [CW-1:0] scan_x,
  input  logic [CW-1:0] scan_y,
  input  logic          btn_down,
  input  logic          btn_up,
  output logic          frame_tick,
  output logic [CW-1:0] pad_top,
  output logic [CW-1:0] pad_bot,
  output logic [CW-1:0] ball_xl,
  output logic [CW-1:0] ball_xr,
  output logic [CW-1:0] ball_yt,
  output logic [CW-1:0] ball_yb,
  output logic          miss
);

  localparam logic [CW-1:0] TICK_Y   = CW'(TICK_ROW);
  localparam logic [CW-1:0] PAD_TOP0 = CW'(SCR_H/2 - PAD_H/2);
  localparam logic [CW-1:0] PAD_SPAN = CW'(PAD_H - 1);
  localparam logic [CW-1:0] PAD_STP  = CW'(PAD_STEP);
  localparam logic [CW-1:0] PAD_LIM  = CW'(SCR_H - PAD_STEP);
  localparam logic [CW-1:0] BALL_SPN = CW'(BALL_SZ - 1);
  localparam logic [CW-1:0] SPD      = CW'(BALL_SPD);
  localparam logic [CW-1:0] X0       = CW'(BALL_X0);
  localparam logic [CW-1:0] Y0       = CW'(BALL_Y0);
  localparam logic [CW-1:0] X_LAST   = CW'(SCR_W - 1);
  localparam logic [CW-1:0] Y_LAST   = CW'(SCR_H - 1);
  localparam logic [CW-1:0] WALL_R   = CW'(WALL_XR);
  localparam logic [CW-1:0] PAD_L    = CW'(PAD_XL);
  localparam logic [CW-1:0] PAD_R    = CW'(PAD_XR);

  logic [CW-1:0] pad_q, bx_q, by_q;
  logic          vx_right_q, vy_down_q, miss_q;
  logic          vx_n, vy_n, escaped, hit_wall, hit_pad;

  assign frame_tick = pix_tick && (scan_y == TICK_Y) && (scan_x == '0);

  assign pad_top = pad_q;
  assign pad_bot = pad_q + PAD_SPAN;
  assign ball_xl = bx_q;
  assign ball_xr = bx_q + BALL_SPN;
  assign ball_yt = by_q;
  assign ball_yb = by_q + BALL_SPN;
  assign miss    = miss_q;

  assign escaped  = ball_xr > X_LAST;
  assign hit_wall = bx_q <= WALL_R;
  assign hit_pad  = (ball_xr >= PAD_L) && (ball_xr <= PAD_R) &&
                    (ball_yb >= pad_q) && (by_q <= pad_bot);

  assign vx_n = hit_wall ? 1'b1 : (hit_pad ? 1'b0 : vx_right_q);
  assign vy_n = (by_q == '0) ? 1'b1 : ((ball_yb >= Y_LAST) ? 1'b0 : vy_down_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pad_q      <= PAD_TOP0;
      bx_q       <= X0;
      by_q       <= Y0;
      vx_right_q <= 1'b1;
      vy_down_q  <= 1'b1;
      miss_q     <= 1'b0;
    end else begin
      miss_q <= 1'b0;
      if (frame_tick) begin
        if (btn_down && (pad_bot < PAD_LIM))
          pad_q <= pad_q + PAD_STP;
        else if (btn_up && (pad_q > PAD_STP))
          pad_q <= pad_q - PAD_STP;
        if (escaped) begin
          bx_q       <= X0;
          by_q       <= Y0;
          vx_right_q <= 1'b1;
          vy_down_q  <= 1'b1;
          miss_q     <= 1'b1;
        end else begin
          vx_right_q <= vx_n;
          vy_down_q  <= vy_n;
          bx_q       <= vx_n ? bx_q + SPD : bx_q - SPD;
          by_q       <= vy_n ? by_q + SPD : by_q - SPD;
        end
      end
    end
  end

  p_hold_no_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_tick |=> $stable(pad_top) && $stable(ball_xl) && $stable(ball_yt));

  p_pad_in_screen_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pad_bot <= Y_LAST && pad_top >= PAD_STP);

  p_miss_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    miss |=> !miss);

  p_miss_reload_r9: assert property (@(posedge clk) disable iff (!rst_n)
    miss |-> (ball_xl == X0) && (ball_yt == Y0));

  p_step_size_r10: assert property (@(posedge clk) disable iff (!rst_n)
    frame_tick |=> miss || (ball_xl == $past(ball_xl) + SPD) || (ball_xl == $past(ball_xl) - SPD));

  p_top_bounce_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_tick && ball_yt == '0 && ball_xr <= X_LAST) |=> ball_yt == SPD);

endmodule

// File: tb/tb_pong_motion.sv
module tb_pong_motion;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pix_tick = 1'b0;
  logic [9:0] scan_x = '0, scan_y = '0;
  logic btn_down = 1'b0, btn_up = 1'b0;
  logic frame_tick, miss;
  logic [9:0] pad_top, pad_bot, ball_xl, ball_xr, ball_yt, ball_yb;

  always #10 clk = ~clk;

  pong_motion dut (
    .clk(clk), .rst_n(rst_n), .pix_tick(pix_tick), .scan_x(scan_x), .scan_y(scan_y),
    .btn_down(btn_down), .btn_up(btn_up), .frame_tick(frame_tick),
    .pad_top(pad_top), .pad_bot(pad_bot), .ball_xl(ball_xl), .ball_xr(ball_xr),
    .ball_yt(ball_yt), .ball_yb(ball_yb), .miss(miss)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  int mtop, mbx, mby, mvx, mvy, mmiss;
  int hits, walls, tops, bots, misses;

  task automatic chk(input int act, input int exp, input string tag);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    mtop = 204; mbx = 320; mby = 240; mvx = 2; mvy = 2; mmiss = 0;
    hits = 0; walls = 0; tops = 0; bots = 0; misses = 0;
  endtask

  task automatic model_step(input bit dn, input bit up);
    int nt;
    nt = mtop;
    if (dn && mtop + 71 < 476) nt = mtop + 4;
    else if (up && mtop > 4) nt = mtop - 4;
    mmiss = 0;
    if (mbx + 7 > 639) begin
      mbx = 320; mby = 240; mvx = 2; mvy = 2; mmiss = 1; misses++;
    end else begin
      if (mby <= 0) begin mvy = 2; tops++; end
      else if (mby + 7 >= 479) begin mvy = -2; bots++; end
      if (mbx <= 35) begin mvx = 2; walls++; end
      else if (mbx + 7 >= 600 && mbx + 7 <= 603 && mby + 7 >= mtop && mby <= mtop + 71) begin
        mvx = -2; hits++;
      end
      mbx += mvx; mby += mvy;
    end
    mtop = nt;
  endtask

  task automatic compare(input string tag);
    chk(pad_top, mtop, {tag, " R4/R5 pad_top"});
    chk(pad_bot, mtop + 71, {tag, " R10 pad_bot"});
    chk(ball_xl, mbx, {tag, " R10 ball_xl"});
    chk(ball_xr, mbx + 7, {tag, " R10 ball_xr"});
    chk(ball_yt, mby, {tag, " R10 ball_yt"});
    chk(ball_yb, mby + 7, {tag, " R10 ball_yb"});
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; pix_tick = 0; scan_x = 0; scan_y = 0; btn_down = 0; btn_up = 0;
    @(negedge clk);
    rst_n = 1'b1;
    model_reset();
    @(negedge clk);
  endtask

  task automatic frame(input bit dn, input bit up, input string tag);
    pix_tick = 1; scan_y = 10'd481; scan_x = 0; btn_down = dn; btn_up = up;
    @(posedge clk); @(negedge clk);
    pix_tick = 0; scan_y = 0; btn_down = 0; btn_up = 0;
    model_step(dn, up);
    compare(tag);
    chk(miss, mmiss, {tag, " R9 miss pulse"});
    @(posedge clk); @(negedge clk);
    if (mmiss) chk(miss, 0, {tag, " R9 miss one cycle"});
  endtask

  task automatic t_reset();
    do_reset();
    compare("reset R3");
    chk(miss, 0, "R3 miss after reset");
    frame(0, 0, "R3 start direction");
  endtask

  task automatic t_decode();
    do_reset();
    pix_tick = 1; scan_y = 481; scan_x = 0; #1 chk(frame_tick, 1, "R1 exact position");
    pix_tick = 0; #1 chk(frame_tick, 0, "R1 no pixel enable");
    pix_tick = 1; scan_y = 480; #1 chk(frame_tick, 0, "R1 row 480");
    scan_y = 481; scan_x = 1; #1 chk(frame_tick, 0, "R1 column 1");
    scan_y = 0; scan_x = 0; #1 chk(frame_tick, 0, "R1 origin");
    pix_tick = 0;
  endtask

  task automatic t_hold();
    do_reset();
    for (int i = 0; i < 20; i++) begin
      pix_tick = 1; scan_x = 10'(i); scan_y = 10'(470 + i); btn_down = i[0]; btn_up = ~i[0];
      if (scan_x == 0 && scan_y == 481) scan_x = 5;
      @(posedge clk); @(negedge clk);
    end
    pix_tick = 0; btn_down = 0; btn_up = 0;
    compare("R2 no strobe hold");
  endtask

  task automatic t_priority();
    do_reset();
    frame(1, 1, "R4 both buttons");
    chk(pad_top, 208, "R4 down wins");
  endtask

  task automatic t_limits();
    do_reset();
    for (int i = 0; i < 60; i++) frame(0, 1, "R5 climb");
    chk(pad_top, 4, "R5 upper stop");
    for (int i = 0; i < 120; i++) frame(1, 0, "R4 descend");
    chk(pad_top, 408, "R4 lower stop top");
    chk(pad_bot, 479, "R4 lower stop bottom");
  endtask

  task automatic t_rally();
    do_reset();
    for (int i = 0; i < 700; i++) begin
      bit dn, up;
      dn = (mtop + 36 < mby + 4);
      up = (mtop + 36 > mby + 4);
      frame(dn, up, "rally");
    end
    chk(hits > 0, 1, "R8 paddle return seen");
    chk(walls > 0, 1, "R7 wall return seen");
    chk(tops > 0, 1, "R6 top bounce seen");
    chk(bots > 0, 1, "R6 bottom bounce seen");
    chk(misses, 0, "R8 tracked paddle never misses");
  endtask

  task automatic t_miss();
    do_reset();
    for (int i = 0; i < 200 && misses == 0; i++) frame(0, 1, "R9 escape run");
    chk(misses, 1, "R9 escape happened");
    chk(ball_xl, 320, "R9 reload column");
    frame(0, 0, "R9 after reload");
    chk(ball_xl, 322, "R9 default direction x");
    chk(ball_yt, 242, "R9 default direction y");
  endtask

  initial begin
    t_reset();
    t_decode();
    t_hold();
    t_priority();
    t_limits();
    t_rally();
    t_miss();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule